// File: doc/BRIEF.md
# Multi-Mode Character Serializer

This block is one transmit lane running on a bit-rate clock. It takes a 10-bit character that has already been line-encoded, holds it, and shifts it onto a single serial output one bit per clock, least significant bit first. A new character is taken on a capture event. The capture event comes from one of three strobe sources. Each source is a level input sampled in the bit-clock domain: a reference strobe, a byte strobe shared by all lanes, or this lane's own byte strobe. The reference strobe has two rate variants. At full rate it runs at one tenth of the bit rate. At half rate it runs at one twentieth, and the block adds a second capture midway between its rising edges.

The block watches the shared strobe and the strobe of a fixed neighbouring lane (lane B) over fixed windows, and from them picks the capture source by itself. A lock input sets how the shift phase relates to the strobe. While the lock input is low, the block pulls its shift phase into line with every capture event. While it is high, the phase stays fixed and the strobe may wander by two bit times either way without losing a character. A holding register sits between the capture event and the shift register, so the strobe phase and the shift phase are independent of each other.

Top module: `tx_multimode_ser`

## Requirements
- R1: The shift register is reloaded from the holding register once per 10-clock frame. It then presents `char_i[0]` on `ser_o` during the first clock after the reload, `char_i[1]` during the second, and so on up to `char_i[9]`. This gives the line order a,b,c,d,e,i,f,g,h,j.
- R2: While `rst` is high at a rising clock edge, the shift register, the holding register and the detectors are cleared. The next clock therefore shows `ser_o` = 0 and `mode_o` = 0 (reference source).
- R3: With `mode_o` = 0 and `full_rate_i` = 1, every rising edge of `ref_stb_i` captures a character, and no midpoint capture takes place.
- R4: With `mode_o` = 0 and `full_rate_i` = 0, every rising edge of `ref_stb_i` captures a character. A second capture follows exactly 10 clocks after each of those captures.
- R5: When the shared strobe `com_stb_i` toggles and `chb_stb_i` stays static, `mode_o` becomes 1. Characters are then captured only on rising edges of `com_stb_i`.
- R6: When both `com_stb_i` and `chb_stb_i` toggle, `mode_o` becomes 2. Characters are then captured only on rising edges of `own_stb_i`.
- R7: Source detection works on windows of 40 clocks. A strobe counts as toggling if at least one rising edge was sampled inside the window. `mode_o` changes only in the clock after the last clock of a window. The encoding is 0 = reference, 1 = shared, 2 = own, and 3 never appears.
- R8: While `lock_en_i` is low, a capture realigns the frame. Let the first clock edge that samples the selected strobe high count as edge 1. `char_i` is taken at edge 2, and the reload happens at edge 7, so `char_i[0]` appears on `ser_o` after edge 7.
- R9: While `lock_en_i` is high, reloads keep a strict 10-clock cadence whatever the strobe timing. A strobe that drifts by up to 2 clocks either way from its locked phase still delivers every character intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_stb_i | input | 1 | Reference strobe (level, sampled) |
| com_stb_i | input | 1 | Byte strobe shared by all lanes |
| chb_stb_i | input | 1 | Byte strobe of lane B, used only for source detection |
| own_stb_i | input | 1 | This lane's own byte strobe |
| full_rate_i | input | 1 | 1: reference at 1/10 bit rate; 0: 1/20 with midpoint capture |
| lock_en_i | input | 1 | 0: realign frame to captures; 1: frame phase frozen |
| char_i | input | CHAR_W | Encoded character, bit 0 sent first |
| ser_o | output | 1 | Serial data |
| mode_o | output | 2 | Detected capture source |

## Verification
The bench builds the block with its default parameters: 10-bit characters, a 40-clock detection window and a realignment offset of 5. The short window lets the bench move through all three sources and back in a few hundred clocks, and shows the clock where each mode switch takes effect. The offset of 5 sits in the middle of the frame, so the bench can nudge the own strobe by two clocks in both directions while locked and confirm that no character is lost. A behavioural model recomputes the serial bit and the detected source on every clock, with the character input changing on every clock, so a capture taken at the wrong clock shows up as a bit mismatch.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;

    typedef enum logic [1:0] {
        MODE_REF = 2'd0,
        MODE_COM = 2'd1,
        MODE_OWN = 2'd2
    } cap_mode_e;

    localparam int STB_N   = 4;
    localparam int STB_REF = 0;
    localparam int STB_COM = 1;
    localparam int STB_CHB = 2;
    localparam int STB_OWN = 3;

endpackage

// File: rtl/tx_stb_edge.sv
module tx_stb_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] stb_i,
    output logic [N-1:0] rise_o
);

    typedef struct packed {
        logic [N-1:0] cur;
        logic [N-1:0] prev;
    } edge_st_t;

    edge_st_t edge_d, edge_q;

    always_comb begin
        edge_d      = edge_q;
        edge_d.cur  = stb_i;
        edge_d.prev = edge_q.cur;
    end

    always_ff @(posedge clk) begin
        if (rst) edge_q <= '0;
        else     edge_q <= edge_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_rise
        assign rise_o[g] = edge_q.cur[g] & ~edge_q.prev[g];
    end

endmodule

// File: rtl/tx_mode_detect.sv
module tx_mode_detect
    import tx_ser_pkg::*;
#(
    parameter int WIN_LEN = 40
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      com_rise_i,
    input  logic      chb_rise_i,
    output cap_mode_e mode_o
);

    localparam int WW = $clog2(WIN_LEN);

    typedef struct packed {
        logic [WW-1:0] win;
        logic          com_seen;
        logic          chb_seen;
        cap_mode_e     mode;
    } det_st_t;

    det_st_t det_d, det_q;

    always_comb begin
        logic com_now;
        logic chb_now;
        det_d   = det_q;
        com_now = det_q.com_seen | com_rise_i;
        chb_now = det_q.chb_seen | chb_rise_i;
        if (det_q.win == WW'(WIN_LEN - 1)) begin
            det_d.win      = '0;
            det_d.com_seen = 1'b0;
            det_d.chb_seen = 1'b0;
            if (!com_now)     det_d.mode = MODE_REF;
            else if (chb_now) det_d.mode = MODE_OWN;
            else              det_d.mode = MODE_COM;
        end else begin
            det_d.win      = det_q.win + 1'b1;
            det_d.com_seen = com_now;
            det_d.chb_seen = chb_now;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det_q      <= '0;
            det_q.mode <= MODE_REF;
        end else begin
            det_q <= det_d;
        end
    end

    assign mode_o = det_q.mode;

endmodule

// File: rtl/tx_capture_sel.sv
module tx_capture_sel
    import tx_ser_pkg::*;
#(
    parameter int HALF_LEN = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  cap_mode_e        mode_i,
    input  logic             full_rate_i,
    input  logic [STB_N-1:0] rise_i,
    output logic             cap_o
);

    localparam int MW = $clog2(HALF_LEN + 1);

    typedef struct packed {
        logic [MW-1:0] mid;
    } sel_st_t;

    sel_st_t sel_d, sel_q;
    logic    mid_hit;
    logic    ref_ev;

    assign ref_ev  = rise_i[STB_REF];
    assign mid_hit = (sel_q.mid == MW'(HALF_LEN));

    always_comb begin
        sel_d = sel_q;
        if (ref_ev && !full_rate_i && mode_i == MODE_REF)
            sel_d.mid = MW'(1);
        else if (mid_hit)
            sel_d.mid = '0;
        else if (sel_q.mid != '0)
            sel_d.mid = sel_q.mid + 1'b1;
    end

    always_comb begin
        unique case (mode_i)
            MODE_COM: cap_o = rise_i[STB_COM];
            MODE_OWN: cap_o = rise_i[STB_OWN];
            default:  cap_o = ref_ev | (mid_hit & ~full_rate_i);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= sel_d;
    end

endmodule

// File: rtl/tx_serial_core.sv
module tx_serial_core #(
    parameter int CHAR_W    = 10,
    parameter int ALIGN_OFS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_i,
    input  logic              lock_en_i,
    input  logic [CHAR_W-1:0] char_i,
    output logic              ser_o,
    output logic              load_o,
    output logic [CHAR_W-1:0] hold_o
);

    localparam int PW = $clog2(CHAR_W);
    localparam logic [PW-1:0] PH_LAST  = PW'(CHAR_W - 1);
    localparam logic [PW-1:0] PH_ALIGN = PW'(CHAR_W - ALIGN_OFS);

    typedef struct packed {
        logic [CHAR_W-1:0] hold;
        logic [CHAR_W-1:0] shift;
        logic [PW-1:0]     ph;
    } core_st_t;

    core_st_t core_d, core_q;

    assign load_o = (core_q.ph == PH_LAST);

    always_comb begin
        core_d = core_q;
        if (load_o) begin
            core_d.shift = core_q.hold;
            core_d.ph    = '0;
        end else begin
            core_d.shift = core_q.shift >> 1;
            core_d.ph    = core_q.ph + 1'b1;
        end
        if (cap_i) begin
            core_d.hold = char_i;
            if (!lock_en_i) core_d.ph = PH_ALIGN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) core_q <= '0;
        else     core_q <= core_d;
    end

    assign ser_o  = core_q.shift[0];
    assign hold_o = core_q.hold;

endmodule

// File: rtl/tx_multimode_ser.sv
module tx_multimode_ser
    import tx_ser_pkg::*;
#(
    parameter int CHAR_W    = 10,
    parameter int WIN_LEN   = 40,
    parameter int ALIGN_OFS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_stb_i,
    input  logic              com_stb_i,
    input  logic              chb_stb_i,
    input  logic              own_stb_i,
    input  logic              full_rate_i,
    input  logic              lock_en_i,
    input  logic [CHAR_W-1:0] char_i,
    output logic              ser_o,
    output logic [1:0]        mode_o
);

    logic [STB_N-1:0]  stb_w;
    logic [STB_N-1:0]  rise_w;
    cap_mode_e         mode_w;
    logic              cap_w;
    logic              load_w;
    logic [CHAR_W-1:0] hold_w;

    always_comb begin
        stb_w          = '0;
        stb_w[STB_REF] = ref_stb_i;
        stb_w[STB_COM] = com_stb_i;
        stb_w[STB_CHB] = chb_stb_i;
        stb_w[STB_OWN] = own_stb_i;
    end

    tx_stb_edge #(.N(STB_N)) edge_i (
        .clk    (clk),
        .rst    (rst),
        .stb_i  (stb_w),
        .rise_o (rise_w)
    );

    tx_mode_detect #(.WIN_LEN(WIN_LEN)) det_i (
        .clk        (clk),
        .rst        (rst),
        .com_rise_i (rise_w[STB_COM]),
        .chb_rise_i (rise_w[STB_CHB]),
        .mode_o     (mode_w)
    );

    tx_capture_sel #(.HALF_LEN(CHAR_W)) sel_i (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode_w),
        .full_rate_i (full_rate_i),
        .rise_i      (rise_w),
        .cap_o       (cap_w)
    );

    tx_serial_core #(.CHAR_W(CHAR_W), .ALIGN_OFS(ALIGN_OFS)) core_i (
        .clk       (clk),
        .rst       (rst),
        .cap_i     (cap_w),
        .lock_en_i (lock_en_i),
        .char_i    (char_i),
        .ser_o     (ser_o),
        .load_o    (load_w),
        .hold_o    (hold_w)
    );

    assign mode_o = mode_w;

endmodule

// File: rtl/tx_multimode_ser_chk.sv
module tx_multimode_ser_chk #(
    parameter int CHAR_W  = 10,
    parameter int WIN_LEN = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              lock_en_i,
    input logic              ser_o,
    input logic [1:0]        mode_o,
    input logic              cap,
    input logic              load,
    input logic [CHAR_W-1:0] hold
);

    localparam int WW = $clog2(WIN_LEN);

    logic [WW-1:0] win_cnt;
    logic [7:0]    gap_cnt;
    logic [7:0]    lock_run;
    logic          seen_load;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt   <= '0;
            gap_cnt   <= '0;
            lock_run  <= '0;
            seen_load <= 1'b0;
        end else begin
            win_cnt <= (win_cnt == WW'(WIN_LEN - 1)) ? '0 : win_cnt + 1'b1;
            if (load)                gap_cnt <= '0;
            else if (gap_cnt != '1)  gap_cnt <= gap_cnt + 1'b1;
            if (!lock_en_i)          lock_run <= '0;
            else if (lock_run != '1) lock_run <= lock_run + 1'b1;
            if (load) seen_load <= 1'b1;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (ser_o == 1'b0 && mode_o == 2'd0)); // R2

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mode_o != 2'd3); // R7

    AST_MODE_AT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_o) |-> win_cnt == '0); // R7

    AST_HOLD_ONLY_ON_CAP: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(hold)); // R8

    AST_LOCK_CADENCE: assert property (@(posedge clk) disable iff (rst)
        (load && seen_load && lock_run >= 8'(CHAR_W)) |-> gap_cnt == 8'(CHAR_W - 1)); // R9

endmodule

bind tx_multimode_ser tx_multimode_ser_chk #(
    .CHAR_W  (CHAR_W),
    .WIN_LEN (WIN_LEN)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .lock_en_i (lock_en_i),
    .ser_o     (ser_o),
    .mode_o    (mode_o),
    .cap       (cap_w),
    .load      (load_w),
    .hold      (hold_w)
);

// File: tb/tx_multimode_ser_tb.sv
module tx_multimode_ser_tb_top;

    localparam int CW    = 10;
    localparam int WIN   = 40;
    localparam int LIMIT = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          full_rate = 1'b1;
    logic          lock_en = 1'b0;
    logic [CW-1:0] char_in = '0;
    logic          ser;
    logic [1:0]    mode;

    int per [4];
    int cnt [4];
    bit lvl [4];

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    started = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R2";

    always #10 clk = ~clk;

    tx_multimode_ser dut_i (
        .clk         (clk),
        .rst         (rst),
        .ref_stb_i   (lvl[0]),
        .com_stb_i   (lvl[1]),
        .chb_stb_i   (lvl[2]),
        .own_stb_i   (lvl[3]),
        .full_rate_i (full_rate),
        .lock_en_i   (lock_en),
        .char_i      (char_in),
        .ser_o       (ser),
        .mode_o      (mode)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    bit          ms1 [4];
    bit          ms2 [4];
    int          mwin, mmode, mmid, mph;
    bit          mcs, mbs;
    logic [CW-1:0] mhold;
    bit          mq [$];

    always @(posedge clk) begin
        bit rz [4];
        bit capx, ldx, cnow, bnow;
        if (rst) begin
            for (int i = 0; i < 4; i++) begin ms1[i] = 0; ms2[i] = 0; end
            mwin = 0; mcs = 0; mbs = 0; mmode = 0; mmid = 0; mph = 0;
            mhold = '0; mq = {};
        end else begin
            for (int i = 0; i < 4; i++) rz[i] = ms1[i] && !ms2[i];
            if (mmode == 0)      capx = rz[0] || (!full_rate && mmid == CW);
            else if (mmode == 1) capx = rz[1];
            else                 capx = rz[3];
            if (rz[0] && !full_rate && mmode == 0) mmid = 1;
            else if (mmid == CW)                   mmid = 0;
            else if (mmid != 0)                    mmid++;
            ldx = (mph == CW - 1);
            if (ldx) begin
                mq = {};
                for (int b = 0; b < CW; b++) mq.push_back(mhold[b]);
                mph = 0;
            end else begin
                if (mq.size() > 0) void'(mq.pop_front());
                mph++;
            end
            if (capx) begin
                mhold = char_in;
                if (!lock_en) mph = CW - 5;
            end
            cnow = mcs || rz[1];
            bnow = mbs || rz[2];
            if (mwin == WIN - 1) begin
                mwin = 0; mcs = 0; mbs = 0;
                mmode = !cnow ? 0 : (bnow ? 2 : 1);
            end else begin
                mwin++; mcs = cnow; mbs = bnow;
            end
            for (int i = 0; i < 4; i++) begin ms2[i] = ms1[i]; ms1[i] = lvl[i]; end
        end
        started = 1'b1;
    end

    // compare at negedge, then advance stimulus
    always @(negedge clk) begin
        bit exp_ser;
        if (started && !done) begin
            exp_ser = (mq.size() > 0) ? mq[0] : 1'b0;
            chk(ser == exp_ser, cur_req, "ser_o", int'(ser), int'(exp_ser));
            chk(mode == 2'(mmode), cur_req, "mode_o", int'(mode), mmode);
        end
        for (int i = 0; i < 4; i++) begin
            if (per[i] == 0) lvl[i] = 1'b0;
            else begin
                cnt[i] = (cnt[i] + 1) % per[i];
                lvl[i] = (cnt[i] < per[i] / 2);
            end
        end
        char_in = CW'($urandom);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic set_per(input int i, input int p, input int ph);
        per[i] = p;
        cnt[i] = ph;
    endtask

    task automatic nudge(input int i, input int d);
        cnt[i] = (cnt[i] + d + per[i]) % per[i];
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin per[i] = 0; cnt[i] = 0; lvl[i] = 0; end
        step(4);
        chk(ser == 1'b0, "R2", "ser_o after reset", int'(ser), 0);
        chk(mode == 2'd0, "R2", "mode_o after reset", int'(mode), 0);
        rst = 1'b0;

        cur_req = "R1 R3 R8";
        full_rate = 1'b1;
        set_per(0, 10, 0);
        step(150);
        cur_req = "R1 R3 R9";
        lock_en = 1'b1;
        step(100);
        chk(mode == 2'd0, "R3", "mode_o reference", int'(mode), 0);

        cur_req = "R1 R4 R8";
        lock_en = 1'b0;
        full_rate = 1'b0;
        set_per(0, 20, 0);
        step(120);
        cur_req = "R1 R4 R9";
        lock_en = 1'b1;
        step(100);
        chk(mode == 2'd0, "R4", "mode_o half rate", int'(mode), 0);

        cur_req = "R5 R7 R8";
        lock_en = 1'b0;
        full_rate = 1'b1;
        set_per(0, 10, 0);
        set_per(1, 10, 3);
        step(100);
        chk(mode == 2'd1, "R5", "mode_o shared", int'(mode), 1);
        cur_req = "R5 R9";
        lock_en = 1'b1;
        step(100);

        cur_req = "R6 R7 R8";
        lock_en = 1'b0;
        set_per(2, 10, 1);
        set_per(3, 10, 6);
        step(100);
        chk(mode == 2'd2, "R6", "mode_o own", int'(mode), 2);
        cur_req = "R6 R9";
        lock_en = 1'b1;
        step(60);
        nudge(3, 2);
        step(30);
        nudge(3, -2);
        step(30);
        nudge(3, -2);
        step(30);
        nudge(3, 2);
        step(30);
        chk(mode == 2'd2, "R9", "mode_o after drift", int'(mode), 2);

        cur_req = "R7";
        set_per(1, 0, 0);
        set_per(2, 0, 0);
        step(1);
        chk(mode == 2'd2, "R7", "mode_o held until window end", int'(mode), 2);
        step(90);
        chk(mode == 2'd0, "R7", "mode_o back to reference", int'(mode), 0);

        cur_req = "R2";
        rst = 1'b1;
        step(2);
        chk(ser == 1'b0, "R2", "ser_o after second reset", int'(ser), 0);
        chk(mode == 2'd0, "R2", "mode_o after second reset", int'(mode), 0);
        rst = 1'b0;
        cur_req = "R1 R3";
        step(60);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule